// File: doc/BRIEF.md
# FFT Sample Entry and Result Readout Sequencer

This block is the operator-facing controller that sits in front of a small four-point transform core. Two slow control switches drive it. Each rising edge of the load switch latches the byte on a shared 8-bit data bus into the next of four sample registers. Once the fourth sample is stored, the block gives the core a one-cycle start pulse and waits for the core's done signal. After that, each rising edge of the output switch moves to the next of four readout phases. In each phase one result word is presented on the same bus, and the bus output-enable is raised.

A single seven-segment digit shows which phase is active. It shows 1 to 4 while samples are entered, stays at 4 while the core computes, and shows 5 to 8 while results are read. The digit is blank when the controller is idle. Both switches are synchronised and edge-detected inside the block, so holding a switch down advances exactly one phase.

Top module: `fftSeqTop`

## Requirements
- R1: While `rstN` is low and right after it is released, the controller is idle. `segOut` is 0, `busOe` is 0, `busOut` is 0, `fftStart` is 0 and all sample registers are 0.
- R2: From idle, and from load phases 1 to 3, a rising edge of `loadSw` stores `busIn` into the next sample register and advances one phase. Sample k sits at `samplesFlat[8k+7:8k]`, and samples are filled in the order 0, 1, 2, 3. Holding the switch high causes only one advance.
- R3: During load phase k (k = 1..4), the display shows digit k. It keeps showing 4 while the core computes and until the first readout.
- R4: After the fourth sample is stored, `fftStart` is high for exactly one cycle per load sequence. At that moment all four samples are present on `samplesFlat`.
- R5: Before `fftDone` has been seen, output-switch edges have no effect: `busOe` stays 0 and the display is unchanged.
- R6: After `fftDone`, each output-switch edge enters the next readout phase j (j = 0..3). In phase j the display shows digit 5+j, `busOe` is 1, and `busOut` equals result word j at `resultsFlat[8j+7:8j]`.
- R7: An output-switch edge in the last readout phase returns the controller to idle, with the display blank and `busOe` 0.
- R8: Load-switch edges while the core computes, while results wait, or during readout leave the sample registers, the display and `busOut` unchanged.
- R9: The segment code is active-high. Bit 0 is segment a, and so on up to bit 6 for segment g. Bit 7 (decimal point) is always 0. The digit codes are 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07 and 8=0x7F, and blank is 0x00.
- R10: Whenever `busOe` is 0, `busOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 50 MHz |
| rstN | input | 1 | Active-low reset |
| loadSw | input | 1 | Asynchronous switch that steps sample entry |
| outSw | input | 1 | Asynchronous switch that steps result readout |
| busIn | input | 8 | Byte read from the shared bus pads |
| busOut | output | 8 | Byte driven onto the shared bus pads |
| busOe | output | 1 | Pad output-enable for the shared bus |
| segOut | output | 8 | Seven-segment code, active-high, bit 7 decimal point |
| fftStart | output | 1 | One-cycle start pulse to the transform core |
| fftDone | input | 1 | Completion indication from the transform core |
| samplesFlat | output | 32 | Four stored samples for the core, sample 0 in the low byte |
| resultsFlat | input | 32 | Four result words from the core, word 0 in the low byte |

## Verification
The bench holds a switch high for many cycles and expects a single advance. A design without the edge detector would run through several phases and show the wrong digit. Output presses are made before done and while the core is busy. A design without the done gate would raise the output-enable early and drive the shared bus against the operator's data. Load presses are made during the busy, waiting and readout phases. A controller that did not ignore them would overwrite a sample or restart the load sequence in the middle of a readout. The press after the fourth readout must return the block to a blank, undriven idle. A counter that wrapped to readout phase 0 instead would show digit 5 again.

// File: rtl/fftSeqPkg.sv
package fftSeqPkg;
  localparam int WORD_W = 8;
  localparam int NPTS   = 4;
  localparam int SLOT_W = $clog2(NPTS);
  localparam int DIG_W  = 4;
  localparam int SEG_W  = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_BUSY,
    ST_READY,
    ST_READ
  } seqState_e;

  typedef struct packed {
    logic              capture;
    logic [SLOT_W-1:0] slot;
    logic              drive;
    logic [SLOT_W-1:0] readSlot;
    logic [DIG_W-1:0]  digit;
  } seqStrobe_t;
endpackage

// File: rtl/swEdge.sv
module swEdge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic swIn,
  output logic rise
);
  logic [STAGES-1:0] syncQ;
  logic              lastQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      lastQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[STAGES-2:0], swIn};
      lastQ <= syncQ[STAGES-1];
    end
  end

  assign rise = syncQ[STAGES-1] & ~lastQ;

  // R2
  edge_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rise |=> !rise);
endmodule

// File: rtl/seqCtrl.sv
module seqCtrl
  import fftSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadEdge,
  input  logic       outEdge,
  input  logic       fftDone,
  output seqStrobe_t strb,
  output logic       fftStart
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NPTS - 1);

  seqState_e         state, stateN;
  logic [SLOT_W-1:0] cnt, cntN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateN;
      cnt   <= cntN;
    end
  end

  always_comb begin
    stateN       = state;
    cntN         = cnt;
    strb.capture = 1'b0;
    strb.slot    = '0;
    unique case (state)
      ST_IDLE: if (loadEdge) begin
        strb.capture = 1'b1;
        stateN       = ST_LOAD;
        cntN         = '0;
      end
      ST_LOAD: begin
        if (cnt == LAST) begin
          stateN = ST_BUSY;
        end else if (loadEdge) begin
          strb.capture = 1'b1;
          strb.slot    = cnt + 1'b1;
          cntN         = cnt + 1'b1;
        end
      end
      ST_BUSY: if (fftDone) stateN = ST_READY;
      ST_READY: if (outEdge) begin
        stateN = ST_READ;
        cntN   = '0;
      end
      ST_READ: if (outEdge) begin
        if (cnt == LAST) begin
          stateN = ST_IDLE;
          cntN   = '0;
        end else begin
          cntN = cnt + 1'b1;
        end
      end
      default: stateN = ST_IDLE;
    endcase
  end

  assign fftStart      = (state == ST_LOAD) && (cnt == LAST);
  assign strb.drive    = (state == ST_READ);
  assign strb.readSlot = cnt;

  always_comb begin
    unique case (state)
      ST_LOAD:            strb.digit = DIG_W'(cnt) + DIG_W'(1);
      ST_BUSY, ST_READY:  strb.digit = DIG_W'(NPTS);
      ST_READ:            strb.digit = DIG_W'(NPTS) + DIG_W'(cnt) + DIG_W'(1);
      default:            strb.digit = '0;
    endcase
  end

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    fftStart |=> !fftStart);

  // R5
  out_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state inside {ST_IDLE, ST_LOAD, ST_BUSY}) && outEdge |=> state != ST_READ);

  // R6
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ) && ($past(state) != ST_READ) |-> $past(state) == ST_READY);

  // R7
  wrap_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ) && (cnt == LAST) && outEdge |=> state == ST_IDLE);
endmodule

// File: rtl/seqData.sv
module seqData
  import fftSeqPkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobe_t               strb,
  input  logic [WORD_W-1:0]        busIn,
  input  logic [NPTS*WORD_W-1:0]   resultsFlat,
  output logic [NPTS*WORD_W-1:0]   samplesFlat,
  output logic [WORD_W-1:0]        busOut,
  output logic                     busOe,
  output logic [SEG_W-1:0]         segOut
);
  logic [NPTS-1:0][WORD_W-1:0] sampleQ;
  logic [NPTS-1:0][WORD_W-1:0] resultW;

  assign resultW = resultsFlat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleQ <= '0;
    end else if (strb.capture) begin
      sampleQ[strb.slot] <= busIn;
    end
  end

  assign samplesFlat = sampleQ;
  assign busOe       = strb.drive;
  assign busOut      = strb.drive ? resultW[strb.readSlot] : '0;

  function automatic logic [SEG_W-1:0] segCode(input logic [DIG_W-1:0] d);
    logic [6:0] gfedcba;
    unique case (d)
      4'd1:    gfedcba = 7'b0000110;
      4'd2:    gfedcba = 7'b1011011;
      4'd3:    gfedcba = 7'b1001111;
      4'd4:    gfedcba = 7'b1100110;
      4'd5:    gfedcba = 7'b1101101;
      4'd6:    gfedcba = 7'b1111101;
      4'd7:    gfedcba = 7'b0000111;
      4'd8:    gfedcba = 7'b1111111;
      4'd9:    gfedcba = 7'b1101111;
      default: gfedcba = 7'b0000000;
    endcase
    return {1'b0, gfedcba};
  endfunction

  assign segOut = segCode(strb.digit);

  // R8
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(sampleQ));
endmodule

// File: rtl/fftSeqTop.sv
module fftSeqTop
  import fftSeqPkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   loadSw,
  input  logic                   outSw,
  input  logic [WORD_W-1:0]      busIn,
  output logic [WORD_W-1:0]      busOut,
  output logic                   busOe,
  output logic [SEG_W-1:0]       segOut,
  output logic                   fftStart,
  input  logic                   fftDone,
  output logic [NPTS*WORD_W-1:0] samplesFlat,
  input  logic [NPTS*WORD_W-1:0] resultsFlat
);
  logic [1:0] swRaw;
  logic [1:0] swRise;
  seqStrobe_t strb;

  assign swRaw = {outSw, loadSw};

  for (genvar i = 0; i < 2; i++) begin : g_sw
    swEdge #(.STAGES(2)) u_edge (
      .clk  (clk),
      .rstN (rstN),
      .swIn (swRaw[i]),
      .rise (swRise[i])
    );
  end

  seqCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .loadEdge (swRise[0]),
    .outEdge  (swRise[1]),
    .fftDone  (fftDone),
    .strb     (strb),
    .fftStart (fftStart)
  );

  seqData u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .busIn       (busIn),
    .resultsFlat (resultsFlat),
    .samplesFlat (samplesFlat),
    .busOut      (busOut),
    .busOe       (busOe),
    .segOut      (segOut)
  );
endmodule

// File: tb/fftSeqTop_tb.sv
module fftSeqTop_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadSw = 1'b0, outSw = 1'b0;
  logic [7:0]  busIn = '0;
  logic [7:0]  busOut;
  logic        busOe;
  logic [7:0]  segOut;
  logic        fftStart;
  logic        fftDone = 1'b0;
  logic [31:0] samplesFlat;
  logic [31:0] resultsFlat = '0;

  int checks = 0, errors = 0, cycles = 0, startCnt = 0;
  logic [31:0] startSamples = '0;

  always #10 clk = ~clk;

  fftSeqTop u_dut (.*);

  always @(negedge clk) if (rstN && fftStart) begin
    startCnt++;
    startSamples = samplesFlat;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected <100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] expSeg(input int d);
    case (d)
      1: return 8'h06;  2: return 8'h5B;  3: return 8'h4F;  4: return 8'h66;
      5: return 8'h6D;  6: return 8'h7D;  7: return 8'h07;  8: return 8'h7F;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic press(input bit isOut, input int hold);
    @(negedge clk);
    if (isOut) outSw = 1'b1; else loadSw = 1'b1;
    repeat (hold) @(negedge clk);
    outSw = 1'b0; loadSw = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    logic [7:0]  smp [4];
    logic [7:0]  res [4];
    logic [31:0] expSamples;
    logic [7:0]  held;
    int          prevStart;
    void'($urandom(32'd5150));

    repeat (3) @(negedge clk);
    chk("R1 seg in reset", segOut, 0);
    chk("R1 oe in reset", busOe, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 seg", segOut, 0);
    chk("R1 busOe", busOe, 0);
    chk("R1 busOut", busOut, 0);
    chk("R1 fftStart", fftStart, 0);
    chk("R1 samples", samplesFlat, 0);

    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < 4; i++) begin
        smp[i] = (r == 0) ? ((i % 2) ? 8'hFF : 8'h00) : 8'($urandom);
        res[i] = (r == 0) ? ((i % 2) ? 8'h00 : 8'hFF) : 8'($urandom);
      end
      expSamples = {smp[3], smp[2], smp[1], smp[0]};

      press(1'b1, 4);
      chk("R5 out press in idle seg", segOut, 0);
      chk("R5 out press in idle oe", busOe, 0);
      chk("R10 idle busOut", busOut, 0);

      prevStart = startCnt;
      for (int i = 0; i < 4; i++) begin
        busIn = smp[i];
        press(1'b0, (r == 0 && i == 1) ? 25 : 3);
        chk("R3 load digit", segOut, expSeg(i + 1));
        chk("R2 sample stored", samplesFlat[8*i +: 8], smp[i]);
        if (r == 0 && i == 1) chk("R2 held switch one step", segOut, expSeg(2));
      end
      chk("R4 one start pulse", startCnt - prevStart, 1);
      chk("R4 samples at start", startSamples, expSamples);

      busIn = ~smp[0];
      press(1'b0, 3);
      chk("R8 load while busy samples", samplesFlat, expSamples);
      chk("R8 load while busy digit", segOut, expSeg(4));
      press(1'b1, 3);
      chk("R5 out while busy oe", busOe, 0);
      chk("R5 out while busy digit", segOut, expSeg(4));
      chk("R10 busy busOut", busOut, 0);

      resultsFlat = {res[3], res[2], res[1], res[0]};
      repeat ($urandom_range(1, 8)) @(negedge clk);
      fftDone = 1'b1;
      @(negedge clk);
      fftDone = 1'b0;
      repeat (2) @(negedge clk);
      chk("R3 digit holds at 4 after done", segOut, expSeg(4));
      chk("R5 oe low before first readout", busOe, 0);

      for (int j = 0; j < 4; j++) begin
        press(1'b1, 3);
        chk("R6 readout oe", busOe, 1);
        chk("R6 readout word", busOut, res[j]);
        chk("R6 readout digit", segOut, expSeg(5 + j));
        if (j == 1) begin
          held = busOut;
          busIn = 8'($urandom);
          press(1'b0, 3);
          chk("R8 load in readout digit", segOut, expSeg(6));
          chk("R8 load in readout bus", busOut, held);
          chk("R8 load in readout samples", samplesFlat, expSamples);
        end
      end
      chk("R4 no extra start", startCnt - prevStart, 1);

      press(1'b1, 3);
      chk("R7 back to blank", segOut, 0);
      chk("R7 oe low", busOe, 0);
      chk("R10 bus released", busOut, 0);
      chk("R9 decimal point low", {31'd0, segOut[7]}, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule